// File: doc/BRIEF.md
# PCI interrupt line router

This block takes eight level-sensitive PCI interrupt request lines and one power-management system control interrupt (SCI) and spreads them over two destination buses: 16 legacy interrupt controller inputs and 24 I/O APIC global system interrupt (GSI) inputs. Each PCI line has a routing byte of its own. The byte names a legacy IRQ number and holds a disable flag. Several lines may share one legacy IRQ, and the legacy output is then the OR of their levels. On the APIC side the routing bytes play no part: each PCI line owns one input at 16 and above.

A small control register picks which line the SCI drives. The SCI is ORed into the GSI with the same number, and also into the legacy output when that number is below 16. A byte-wide write/read port reaches all nine registers. Every output is a flop fed from combinational routing logic, so a change in any level or register shows at the outputs exactly one clock later.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte reads 0x80, the control register reads 0x00 (SCI on IRQ 9), and all legacy and GSI outputs are 0.
- R2: Register map on `reg_addr`: addresses 0 to 3 hold the routing bytes of lines A to D (bits 0 to 3 of `pirq_lvl`), 4 to 7 hold lines E to H (bits 4 to 7), and 8 holds the control register, whose bits 2:0 are stored and whose bits 7:3 read 0. A write takes effect at the clock edge where `reg_we` is high, and `reg_rdata` shows the stored value combinationally. Addresses 9 to 15 read 0 and writes to them change nothing.
- R3: In a routing byte, bits 3:0 give the legacy IRQ number and bit 7 set to 1 disables the route. A disabled line drives no legacy output.
- R4: Legacy output i is the OR of the levels of all enabled lines whose IRQ field equals i. The SCI term of R7 is added to this.
- R5: GSI 16+n follows PCI line n whatever its routing byte holds.
- R6: Control bits 2:0 select the SCI line: 0 gives 9, 1 gives 10, 2 gives 11, 4 gives 20 and 5 gives 21. Codes 3, 6 and 7 leave the SCI unrouted.
- R7: The SCI level is ORed into the GSI of its selected line, and into the legacy output of the same number when that number is below 16.
- R8: GSIs 0 to 15 are driven only by the SCI, so at most one of them is high at a time.
- R9: Outputs update on the clock edge after a change of input level or register value, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| pirq_lvl | input | 8 | PCI interrupt levels, bit n is line n (A is 0) |
| sci_lvl | input | 1 | SCI level |
| leg_irq | output | 16 | Legacy controller interrupt levels |
| gsi | output | 24 | I/O APIC interrupt levels |

## Verification
On every cycle the assertions check the fixed parts of the routing. Each upper GSI follows its PCI line one cycle later. The low GSIs are never more than one-hot. With all sources quiet the outputs are quiet, and with the SCI unrouted and the PCI lines low nothing is raised. They also check that reset clears the outputs. The bench's scenarios cover what depends on register contents: the OR of shared routes, disabled routes, each SCI select code, the register map including the ignored addresses, and the one-cycle delay after a write. A scoreboard compares these against a model built from shadow copies of the registers, over directed cases and random routing and levels.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int N_PIRQ = 8,
  parameter int N_LEG  = 16,
  parameter int N_GSI  = 24,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [N_PIRQ-1:0] pirq_lvl,
  input  logic              sci_lvl,
  output logic [N_LEG-1:0]  leg_irq,
  output logic [N_GSI-1:0]  gsi
);
  localparam int LW = $clog2(N_LEG);
  localparam int GW = $clog2(N_GSI);
  localparam logic [7:0] ROUTE_RST = 8'h80;

  logic [7:0]       route [N_PIRQ];
  logic [2:0]       sci_sel;
  logic [GW-1:0]    sci_line;
  logic             sci_ok;
  logic [N_LEG-1:0] leg_d;
  logic [N_GSI-1:0] gsi_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < N_PIRQ; n++) route[n] <= ROUTE_RST;
      sci_sel <= 3'd0;
    end else if (reg_we) begin
      for (int n = 0; n < N_PIRQ; n++)
        if (reg_addr == AW'(n)) route[n] <= reg_wdata;
      if (reg_addr == AW'(N_PIRQ)) sci_sel <= reg_wdata[2:0];
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    for (int n = 0; n < N_PIRQ; n++)
      if (reg_addr == AW'(n)) reg_rdata = route[n];
    if (reg_addr == AW'(N_PIRQ)) reg_rdata = {5'b0, sci_sel};
  end

  always_comb begin
    sci_ok = 1'b1;
    case (sci_sel)
      3'd0:    sci_line = GW'(9);
      3'd1:    sci_line = GW'(10);
      3'd2:    sci_line = GW'(11);
      3'd4:    sci_line = GW'(20);
      3'd5:    sci_line = GW'(21);
      default: begin sci_line = '0; sci_ok = 1'b0; end
    endcase
  end

  always_comb begin
    leg_d = '0;
    gsi_d = '0;
    for (int n = 0; n < N_PIRQ; n++) begin
      if (pirq_lvl[n] && !route[n][7]) leg_d[route[n][LW-1:0]] = 1'b1;
      gsi_d[N_LEG+n] = pirq_lvl[n];
    end
    if (sci_lvl && sci_ok) begin
      gsi_d[sci_line] = 1'b1;
      if (sci_line < GW'(N_LEG)) leg_d[sci_line[LW-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leg_irq <= '0;
      gsi     <= '0;
    end else begin
      leg_irq <= leg_d;
      gsi     <= gsi_d;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (leg_irq == '0 && gsi == '0)); // R1

  for (genvar n = 0; n < N_PIRQ; n++) begin : g_ast_gsi
    if (N_LEG + n != 20 && N_LEG + n != 21) begin : g_plain
      AST_GSI_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> gsi[N_LEG+n] == $past(pirq_lvl[n])); // R5
    end
  end

  AST_LOW_GSI_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gsi[N_LEG-1:0])); // R8

  AST_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_lvl == '0 && !sci_lvl) |=> (leg_irq == '0 && gsi == '0)); // R4

  AST_SCI_UNROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sci_ok && pirq_lvl == '0) |=> (leg_irq == '0 && gsi == '0)); // R6
endmodule

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [7:0] pirq_lvl = 0;
  logic       sci_lvl = 0;
  logic [15:0] leg_irq;
  logic [23:0] gsi;

  int checks = 0, fails = 0;
  logic [7:0] sh_route [8];
  logic [2:0] sh_sel;
  logic [39:0] expq [$];
  string       tagq [$];

  always #2.5 clk = ~clk;

  pirq_router dut (.*);

  function automatic logic [39:0] model(logic [7:0] p, logic s);
    logic [15:0] l = '0;
    logic [23:0] g = '0;
    int line;
    case (sh_sel)
      3'd0: line = 9; 3'd1: line = 10; 3'd2: line = 11;
      3'd4: line = 20; 3'd5: line = 21; default: line = -1;
    endcase
    for (int n = 0; n < 8; n++) begin
      if (p[n] && !sh_route[n][7]) l[sh_route[n][3:0]] = 1'b1;
      if (p[n]) g[16+n] = 1'b1;
    end
    if (s && line >= 0) begin
      g[line] = 1'b1;
      if (line < 16) l[line] = 1'b1;
    end
    return {l, g};
  endfunction

  task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] p, logic s, string tag);
    @(negedge clk);
    pirq_lvl = p;
    sci_lvl = s;
    expq.push_back(model(p, s));
    tagq.push_back(tag);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    logic [39:0] old;
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    old = model(pirq_lvl, sci_lvl);
    @(negedge clk);
    reg_we = 0;
    chk("R9 outputs hold until the edge after a write", {leg_irq, gsi}, old);
    if (a < 8) sh_route[a] = d;
    else if (a == 8) sh_sel = d[2:0];
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  always begin
    @(posedge clk);
    #1;
    if (expq.size() > 0) begin
      logic [39:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(t, {leg_irq, gsi}, e);
    end
  end

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < 8; n++) sh_route[n] = 8'h80;
    sh_sel = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 outputs after reset", {leg_irq, gsi}, 40'h0);
    for (int a = 0; a < 8; a++) rd(4'(a), 8'h80, "R1 routing byte default");
    rd(4'd8, 8'h00, "R1 control default");

    drive(8'hFF, 1'b0, "R3 R5 defaults disabled, GSIs follow");
    drive(8'h00, 1'b1, "R7 SCI on IRQ 9 by default");
    drive(8'h00, 1'b0, "R4 all quiet");

    wr(4'd0, 8'h05); wr(4'd2, 8'h05); wr(4'd5, 8'h05); wr(4'd7, 8'h8C);
    rd(4'd5, 8'h05, "R2 group E-H write readback");
    rd(4'd2, 8'h05, "R2 group A-D write readback");
    drive(8'h01, 1'b0, "R4 single line on shared IRQ 5");
    drive(8'h04, 1'b0, "R4 line C on IRQ 5");
    drive(8'h25, 1'b0, "R4 three lines share IRQ 5");
    drive(8'h80, 1'b0, "R3 disabled line H gives no legacy IRQ");
    drive(8'h00, 1'b0, "R9 level drop seen one cycle later");

    for (int c = 0; c < 8; c++) begin
      wr(4'd8, 8'(c) | 8'hF8);
      rd(4'd8, 8'(c), "R2 control keeps bits 2:0");
      drive(8'h00, 1'b1, "R6 R7 SCI select code");
      drive(8'h10, 1'b1, "R6 R7 SCI with line E");
    end

    wr(4'd8, 8'h01);
    for (int a = 9; a < 16; a++) wr(4'(a), 8'h3C);
    for (int a = 9; a < 16; a++) rd(4'(a), 8'h00, "R2 unused address reads 0");
    rd(4'd0, 8'h05, "R2 unused writes left route A");
    rd(4'd8, 8'h01, "R2 unused writes left control");
    drive(8'h01, 1'b1, "R2 routing intact after unused writes");

    wr(4'd3, 8'h0A); wr(4'd8, 8'h01);
    drive(8'h08, 1'b1, "R4 R7 line D and SCI share IRQ 10");
    drive(8'h08, 1'b0, "R7 SCI off keeps line D");

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(3) == 0) begin
        int a = $urandom_range(8);
        logic [7:0] d = 8'($urandom);
        if ($urandom_range(1) == 0) d[3:2] = 2'b01;
        wr(4'(a), d);
      end
      drive(8'($urandom), 1'($urandom), "R4 R5 R7 random routing and levels");
    end
    drive(8'h00, 1'b0, "R4 final quiet");
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule